// File: doc/BRIEF.md
# Addressed I/O Port Bus Interface

This block is the processor-bus face of a small peripheral. The peripheral answers to four consecutive addresses on a shared 8-bit data bus: two general I/O ports, an interrupt control register and a timer register. Addressing takes two instruction cycles. In the first cycle the bus carries an address. The block compares that byte against its base, keeps the outcome, and uses it to qualify the transfer command in the next cycle.

Each instruction cycle lasts one or more clocks. A strobe marks the last clock of the cycle. A 5-bit command code comes from the processor during the cycle. The write command loads the bus byte into the addressed register when the cycle closes. The read command makes the block source the addressed port's pin value onto the bus. The bus is modelled as separate in and out vectors plus an output enable. An active-low drive indicator runs alongside the enable and tells the system which way data is flowing on the bus. The timer function and the pad circuits sit elsewhere. This block only holds the timer and control bytes that are written to them.

Top module: `ioport_bus_if`

## Requirements
- R1: While `rst` is high at a clock edge, all four registers clear to 0, the held match clears, `bus_oe` is 0, `bus_out` is 0 and `drive_n` is 1.
- R2: At each strobe edge the bus byte is compared with the base. A match exists when bits 7:2 equal `BASE_ADDR`. Bits 1:0 then select the target: 0 port A, 1 port B, 2 interrupt control, 3 timer. The result applies to the next instruction cycle only. A non-matching byte clears the match.
- R3: Write command 0x1A, when the previous cycle matched, loads `bus_in` into the selected register at the strobe edge that ends the transfer cycle.
- R4: A write command with no held match changes no register.
- R5: Read command 0x1B, when the previous cycle matched with target 0 or 1, sets `bus_oe` from the first clock edge after the command is seen. It stays set until one edge after the command goes away. While `bus_oe` is 1, `bus_out` carries the selected pin value from the preceding edge. Otherwise `bus_out` is 0.
- R6: A read whose held target is 2 or 3 never sets `bus_oe`.
- R7: `drive_n` is always the inverse of `bus_oe`.
- R8: Every other command code, including 0x0F, 0x10 and 0x13, changes no register and sets no drive.
- R9: Registers change only at strobe edges. A write's new value is not visible before the cycle's final edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | High on the last clock of each instruction cycle |
| cmd | input | 5 | Command code from the processor |
| bus_in | input | 8 | Data bus as seen by the block |
| bus_out | output | 8 | Data sourced onto the bus |
| bus_oe | output | 1 | High while `bus_out` drives the bus |
| drive_n | output | 1 | Active-low bus-drive indicator |
| pa_pin | input | 8 | Port A pin levels, read by the read command |
| pb_pin | input | 8 | Port B pin levels, read by the read command |
| pa_q | output | 8 | Port A output latch |
| pb_q | output | 8 | Port B output latch |
| ictl_q | output | 8 | Interrupt control register |
| tmr_q | output | 8 | Timer register |

## Verification
The assertions assume that `cmd` and `bus_in` change only between clock edges and stay constant for a whole instruction cycle. They also assume that `cyc_stb` is high on exactly one clock per cycle. The stimulus applies every input one nanosecond after the edge and holds it across the cycle. Cycle lengths of one to four clocks are used, and the strobe sits on the last clock of each. Random traffic mixes matching and non-matching addresses, all command codes and changing pin values. This lets the reference model cover reads that reach into the next cycle.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  localparam int SEL_W = 2;
  localparam int NREG  = 1 << SEL_W;
  localparam int NPORT = 2;
  localparam int CMD_W = 5;
  localparam logic [CMD_W-1:0] CMD_WR = 5'h1A;
  localparam logic [CMD_W-1:0] CMD_RD = 5'h1B;
  typedef enum logic [SEL_W-1:0] {
    TGT_PA   = 2'd0,
    TGT_PB   = 2'd1,
    TGT_ICTL = 2'd2,
    TGT_TMR  = 2'd3
  } tgt_e;
endpackage

// File: rtl/ioport_addr_match.sv
module ioport_addr_match
  import ioport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-SEL_W-1:0] BASE = (DATA_W-SEL_W)'(45)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [DATA_W-1:0] bus_in,
  output logic              hit,
  output tgt_e              sel
);
  logic is_ours;
  assign is_ours = (bus_in[DATA_W-1:SEL_W] == BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit <= 1'b0;
      sel <= TGT_PA;
    end else if (stb) begin
      hit <= is_ours;
      sel <= is_ours ? tgt_e'(bus_in[SEL_W-1:0]) : TGT_PA;
    end
  end

  // R2: a foreign byte at a strobe edge drops the held match
  p_miss_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (stb && (bus_in[DATA_W-1:SEL_W] != BASE)) |=> !hit);
  // R2: the match is held between strobes
  p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
    (!stb && !$past(rst)) |=> $stable(hit));
endmodule

// File: rtl/ioport_regs.sv
module ioport_regs
  import ioport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          stb,
  input  logic [CMD_W-1:0]              cmd,
  input  logic                          hit,
  input  tgt_e                          sel,
  input  logic [DATA_W-1:0]             bus_in,
  output logic [NREG-1:0][DATA_W-1:0]   q
);
  logic wr_go;
  assign wr_go = stb && hit && (cmd == CMD_WR);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q[g] <= '0;
      else if (wr_go && (sel == tgt_e'(g))) q[g] <= bus_in;
    end
  end

  // R4 / R8: no qualified write at this strobe, nothing moves
  p_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    (stb && !(hit && cmd == CMD_WR)) |=> $stable(q));
  // R9: registers are frozen between strobes
  p_mid_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    (!stb) |=> $stable(q));
endmodule

// File: rtl/ioport_rd_drive.sv
module ioport_rd_drive
  import ioport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [CMD_W-1:0]              cmd,
  input  logic                          hit,
  input  tgt_e                          sel,
  input  logic [NPORT-1:0][DATA_W-1:0]  pins,
  output logic [DATA_W-1:0]             bus_out,
  output logic                          bus_oe,
  output logic                          drive_n
);
  localparam logic [SEL_W-1:0] NPORT_S = SEL_W'(NPORT);

  logic              rd_go;
  logic [DATA_W-1:0] pick;

  assign rd_go = (cmd == CMD_RD) && hit && (sel < NPORT_S);

  always_comb begin
    pick = '0;
    for (int i = 0; i < NPORT; i++)
      if (sel == tgt_e'(i)) pick = pins[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe  <= 1'b0;
      drive_n <= 1'b1;
      bus_out <= '0;
    end else begin
      bus_oe  <= rd_go;
      drive_n <= !rd_go;
      bus_out <= rd_go ? pick : '0;
    end
  end

  // R6: only port targets may be driven
  p_ports_only_r6: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> ($past(sel) < NPORT_S));
  // R5: drive follows a held match
  p_needs_hit_r5: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> $past(hit));
  // R8: drive only after the read code
  p_read_code_r8: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> ($past(cmd) == CMD_RD));
  // R7: indicator polarity
  p_polarity_r7: assert property (@(posedge clk) disable iff (rst)
    drive_n == !bus_oe);
endmodule

// File: rtl/ioport_bus_if.sv
module ioport_bus_if
  import ioport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-SEL_W-1:0] BASE_ADDR = (DATA_W-SEL_W)'(45)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_stb,
  input  logic [4:0]        cmd,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              drive_n,
  input  logic [DATA_W-1:0] pa_pin,
  input  logic [DATA_W-1:0] pb_pin,
  output logic [DATA_W-1:0] pa_q,
  output logic [DATA_W-1:0] pb_q,
  output logic [DATA_W-1:0] ictl_q,
  output logic [DATA_W-1:0] tmr_q
);
  logic                         hit;
  tgt_e                         sel;
  logic [NREG-1:0][DATA_W-1:0]  regs_q;
  logic [NPORT-1:0][DATA_W-1:0] pins;

  assign pins[TGT_PA] = pa_pin;
  assign pins[TGT_PB] = pb_pin;

  ioport_addr_match #(.DATA_W(DATA_W), .BASE(BASE_ADDR)) u_match (
    .clk(clk), .rst(rst), .stb(cyc_stb), .bus_in(bus_in),
    .hit(hit), .sel(sel)
  );

  ioport_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .stb(cyc_stb), .cmd(cmd), .hit(hit),
    .sel(sel), .bus_in(bus_in), .q(regs_q)
  );

  ioport_rd_drive #(.DATA_W(DATA_W)) u_drive (
    .clk(clk), .rst(rst), .cmd(cmd), .hit(hit), .sel(sel),
    .pins(pins), .bus_out(bus_out), .bus_oe(bus_oe), .drive_n(drive_n)
  );

  assign pa_q   = regs_q[TGT_PA];
  assign pb_q   = regs_q[TGT_PB];
  assign ictl_q = regs_q[TGT_ICTL];
  assign tmr_q  = regs_q[TGT_TMR];
endmodule

// File: tb/ioport_bus_if_test.sv
module ioport_bus_if_test;
  localparam int BASE = 45;                 // addresses 0xB4..0xB7
  localparam logic [7:0] A_PA = 8'hB4, A_PB = 8'hB5, A_IC = 8'hB6, A_TM = 8'hB7;
  localparam logic [4:0] WR = 5'h1A, RD = 5'h1B;

  logic clk = 0, rst = 1, stb = 0;
  logic [4:0] cmd = 0;
  logic [7:0] bus_in = 0, pa_pin = 0, pb_pin = 0;
  logic [7:0] bus_out, pa_q, pb_q, ictl_q, tmr_q;
  logic bus_oe, drive_n;

  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  ioport_bus_if uut (
    .clk(clk), .rst(rst), .cyc_stb(stb), .cmd(cmd), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .drive_n(drive_n),
    .pa_pin(pa_pin), .pb_pin(pb_pin),
    .pa_q(pa_q), .pb_q(pb_q), .ictl_q(ictl_q), .tmr_q(tmr_q)
  );

  // behavioural reference, advanced on every edge
  int m_hit = 0, m_sel = 0, m_oe = 0, m_out = 0;
  int m_reg [4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    int n_oe, n_out;
    if (rst) begin
      m_hit = 0; m_sel = 0; m_oe = 0; m_out = 0;
      foreach (m_reg[i]) m_reg[i] = 0;
    end else begin
      n_oe  = (cmd == RD && m_hit == 1 && m_sel < 2) ? 1 : 0;
      n_out = n_oe ? ((m_sel == 0) ? int'(pa_pin) : int'(pb_pin)) : 0;
      if (stb) begin
        if (cmd == WR && m_hit == 1) m_reg[m_sel] = int'(bus_in);
        if (int'(bus_in[7:2]) == BASE) begin m_hit = 1; m_sel = int'(bus_in[1:0]); end
        else begin m_hit = 0; m_sel = 0; end
      end
      m_oe = n_oe; m_out = n_out;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk("R5 bus_oe", int'(bus_oe), m_oe);
    chk("R5 bus_out", int'(bus_out), m_out);
    chk("R7 drive_n", int'(drive_n), 1 - m_oe);
    chk("R3 pa_q", int'(pa_q), m_reg[0]);
    chk("R3 pb_q", int'(pb_q), m_reg[1]);
    chk("R3 ictl_q", int'(ictl_q), m_reg[2]);
    chk("R3 tmr_q", int'(tmr_q), m_reg[3]);
  end

  task automatic cyc(input logic [4:0] c, input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      cmd = c; bus_in = b; stb = (i == n - 1);
      @(posedge clk); #1;
    end
    stb = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pa_q", int'(pa_q), 0);
    chk("R1 reset oe", int'(bus_oe), 0);
    chk("R1 reset drive_n", int'(drive_n), 1);
    chk("R1 reset bus_out", int'(bus_out), 0);
    rst = 0;

    // R3/R9: write port A over a two-clock cycle
    cyc(5'h00, A_PA, 1);
    cmd = WR; bus_in = 8'h5C; stb = 0;
    @(posedge clk); #1;
    chk("R9 not yet written", int'(pa_q), 0);
    stb = 1; @(posedge clk); #1; stb = 0;
    chk("R3 port A written", int'(pa_q), 8'h5C);

    // R2: each target code
    cyc(5'h00, A_PB, 1); cyc(WR, 8'h11, 2);
    cyc(5'h00, A_IC, 2); cyc(WR, 8'h22, 1);
    cyc(5'h00, A_TM, 3); cyc(WR, 8'h33, 2);
    chk("R2 port B", int'(pb_q), 8'h11);
    chk("R2 ictl", int'(ictl_q), 8'h22);
    chk("R2 timer", int'(tmr_q), 8'h33);

    // R4: foreign address then write
    cyc(5'h00, 8'h34, 1); cyc(WR, 8'hEE, 1);
    chk("R4 pa unchanged", int'(pa_q), 8'h5C);
    chk("R4 timer unchanged", int'(tmr_q), 8'h33);
    // R2: match lasts one cycle only
    cyc(5'h00, A_PB, 1); cyc(5'h00, 8'h00, 1); cyc(WR, 8'h99, 1);
    chk("R2 match expired", int'(pb_q), 8'h11);

    // R5: read port A, drive extends one clock into next cycle
    pa_pin = 8'hA7; pb_pin = 8'h3C;
    cyc(5'h00, A_PA, 1);
    cmd = RD; bus_in = 8'h00; stb = 0;
    @(posedge clk); #1;
    chk("R5 drive on", int'(bus_oe), 1);
    chk("R5 data", int'(bus_out), 8'hA7);
    chk("R7 indicator low", int'(drive_n), 0);
    stb = 1; @(posedge clk); #1; stb = 0; cmd = 0;
    chk("R5 drive tail", int'(bus_oe), 1);
    @(posedge clk); #1;
    chk("R5 drive off", int'(bus_oe), 0);
    chk("R5 bus idle", int'(bus_out), 0);

    // R6: read of control / timer addresses
    cyc(5'h00, A_IC, 1); cmd = RD; @(posedge clk); #1;
    chk("R6 no drive ictl", int'(bus_oe), 0);
    stb = 1; @(posedge clk); #1; stb = 0;
    cyc(5'h00, A_TM, 1); cyc(RD, 8'h00, 2);
    chk("R6 no drive timer", int'(bus_oe), 0);

    // R8: other codes with a live match
    foreach (m_reg[i]) begin end
    cyc(5'h00, A_PA, 1); cyc(5'h0F, 8'h01, 1);
    chk("R8 code 0F pa", int'(pa_q), 8'h5C);
    cyc(5'h00, A_PB, 1); cyc(5'h13, 8'h02, 1);
    chk("R8 code 13 pb", int'(pb_q), 8'h11);
    chk("R8 no drive", int'(bus_oe), 0);
    cyc(5'h00, A_IC, 1); cyc(5'h10, 8'h03, 1);
    chk("R8 code 10 ictl", int'(ictl_q), 8'h22);

    // random mix checked by the model every clock
    for (int k = 0; k < 400; k++) begin
      logic [7:0] b;
      logic [4:0] c;
      b = ($urandom_range(0, 1) == 1) ? (8'hB4 | 8'($urandom_range(0, 3))) : 8'($urandom);
      case ($urandom_range(0, 3))
        0: c = WR;
        1: c = RD;
        default: c = 5'($urandom);
      endcase
      pa_pin = 8'($urandom); pb_pin = 8'($urandom);
      cyc(c, b, $urandom_range(1, 4));
    end

    repeat (3) @(posedge clk);
    #1;
    finish_run();
  end
endmodule